// File: doc/BRIEF.md
# Programmable Tick-Rate Generator Bank

The block holds six programmable frequency generators. Each one picks a source tick stream, divides it by a programmable ratio and drives a gated output tick stream. Everything runs on one fast system clock; sources and outputs are one-cycle enable pulses, not real clocks. Two 32-bit control registers, written and read through a plain register port, hold the configuration. Each register carries three packed 10-bit generator slots.

A parameter selects one of two layouts. In the legacy layout each slot has a source-select bit and an enable bit, and division is even-only. In the extended layout each slot has a 2-bit source code in which zero means off, and each register has a scale bit that picks between even-only and unit-step division.

A small command port enables, disables or re-sources one generator at a time. In the extended layout it remembers the last non-zero source code, so a generator that was switched off comes back on its previous source.

Top module: `freq_gen_bank`

## Requirements
- R1: While reset is asserted, and right after it, both control registers read as zero and every output tick is low. In the extended layout the remembered source code of every generator resets to 1.
- R2: A register read returns the stored value of the selected register (`reg_rsel`) with no delay. The stored value is what was written, with bits 31:30 forced to zero in the legacy layout and only bit 31 forced to zero in the extended layout.
- R3: Generator g lives in register g/3 at bit offset 10*(g mod 3). Within a slot, bits [9:2] hold the divider code N.
- R4: In the legacy layout, slot bit 1 enables the generator. Slot bit 0 selects the source: 0 for the CPU tick, 1 for the auxiliary tick. The divide ratio is 2*(N+1).
- R5: In the extended layout, slot bits [1:0] are the source code: 0 means off, 1 the second auxiliary tick, 2 the CPU tick, 3 the auxiliary tick.
- R6: In the extended layout, register bit 30 sets the scale for the three generators of that register. When it is set, the ratio is N+1. When it is clear, the ratio is 2*(N+1).
- R7: An active generator with ratio D emits an output tick in the same cycle as every D-th tick of its selected source, counted from the last reload. With D=1, source ticks pass straight through. Ratios reach 512.
- R8: A generator that is off keeps its output low and holds its counter at zero.
- R9: A register write to the register holding a slot, or an accepted command to that generator, reloads its counter. Counting then restarts from zero.
- R10: Extended layout commands (`cmd_op`: 1 enable, 2 disable, 3 set source). Disable writes code 0 and keeps the remembered code. Enable writes the remembered code back. Set source with a non-zero code updates the remembered code, and also writes the slot only if the generator is on. Any register write with a non-zero code in a slot also updates that slot's remembered code.
- R11: Legacy layout commands. Enable sets slot bit 1 and disable clears it. Set source clears bit 0 for code 2 and sets it for code 3. Other codes leave the slot unchanged.
- R12: A command in the same cycle as a register write is dropped. So is a command with `cmd_gen` of 6 or above, and one with `cmd_op` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Register index for the write |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Register index for the read |
| reg_rdata | output | 32 | Read data of the selected register |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 none, 1 enable, 2 disable, 3 set source |
| cmd_gen | input | 3 | Target generator |
| cmd_src | input | 2 | Source code for set source |
| tick_cpu | input | 1 | CPU-rate source tick |
| tick_aux | input | 1 | Auxiliary source tick |
| tick_aux2 | input | 1 | Second auxiliary source tick |
| gen_tick | output | 6 | Output ticks, bit g from generator g |

## Verification
Both layouts are instantiated side by side and given identical stimulus. Three source-tick patterns are used. Random sparse ticks separate generators that share a ratio but use different sources. Always-on ticks expose off-by-one errors in the ratio, including the 512 and pass-through extremes. Quiet periods show that a generator does not advance without its own source. Directed command sequences tell apart the remembered source code and the visible slot code, while same-cycle write and command collisions and out-of-range indices show that dropped commands leave the slots untouched.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
  localparam int DATA_W        = 32;
  localparam int SLOT_W        = 10;
  localparam int DIV_W         = 8;
  localparam int RATIO_W       = DIV_W + 2;
  localparam int SLOTS_PER_REG = 3;
  localparam int SCALE_POS     = 30;
  localparam int FIELD_BITS    = SLOTS_PER_REG * SLOT_W;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_AUX2 = 2'd1,
    SRC_CPU  = 2'd2,
    SRC_AUX  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    OP_NOP     = 2'd0,
    OP_ENABLE  = 2'd1,
    OP_DISABLE = 2'd2,
    OP_SETSRC  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic               active;
    src_e               src;
    logic [RATIO_W-1:0] ratio;
  } gen_cfg_t;
endpackage

// File: rtl/fgb_regs.sv
module fgb_regs
  import fgb_pkg::*;
#(
  parameter bit EXTENDED = 1'b1,
  parameter int NUM_GEN  = 6,
  parameter int NUM_REGS = 2,
  parameter int RSEL_W   = 1,
  parameter int GEN_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [RSEL_W-1:0]         reg_wsel,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic [RSEL_W-1:0]         reg_rsel,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [GEN_W-1:0]          cmd_gen,
  input  logic [1:0]                cmd_src,
  output logic [NUM_GEN*SLOT_W-1:0] slots,
  output logic [NUM_REGS-1:0]       scale,
  output logic [NUM_GEN-1:0]        reload
);
  localparam logic [DATA_W-1:0] FIELD_MASK = (DATA_W'(1) << FIELD_BITS) - DATA_W'(1);
  localparam logic [DATA_W-1:0] KEEP_MASK  =
    FIELD_MASK | (EXTENDED ? (DATA_W'(1) << SCALE_POS) : '0);

  logic [DATA_W-1:0] ctrl_q [NUM_REGS];
  logic [1:0]        mem_q  [NUM_GEN];
  logic              wsel_ok, rsel_ok, cmd_go;

  assign wsel_ok = int'(reg_wsel) < NUM_REGS;
  assign rsel_ok = int'(reg_rsel) < NUM_REGS;
  assign cmd_go  = cmd_valid && !reg_wr && (cmd_op != OP_NOP) && (int'(cmd_gen) < NUM_GEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) ctrl_q[r] <= '0;
      for (int g = 0; g < NUM_GEN; g++)  mem_q[g]  <= SRC_AUX2;
    end else if (reg_wr) begin
      if (wsel_ok) begin
        ctrl_q[reg_wsel] <= reg_wdata & KEEP_MASK;
        for (int g = 0; g < NUM_GEN; g++) begin
          if (EXTENDED && (g / SLOTS_PER_REG) == int'(reg_wsel) &&
              reg_wdata[(g % SLOTS_PER_REG)*SLOT_W +: 2] != 2'b00)
            mem_q[g] <= reg_wdata[(g % SLOTS_PER_REG)*SLOT_W +: 2];
        end
      end
    end else if (cmd_go) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (int'(cmd_gen) == g) begin
          if (EXTENDED) begin
            case (cmd_op)
              OP_ENABLE:
                ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W +: 2] <= mem_q[g];
              OP_DISABLE:
                ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W +: 2] <= 2'b00;
              OP_SETSRC: begin
                if (cmd_src != 2'b00) begin
                  mem_q[g] <= cmd_src;
                  if (ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W +: 2] != 2'b00)
                    ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W +: 2] <= cmd_src;
                end
              end
              default: ;
            endcase
          end else begin
            case (cmd_op)
              OP_ENABLE:
                ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W + 1] <= 1'b1;
              OP_DISABLE:
                ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W + 1] <= 1'b0;
              OP_SETSRC: begin
                if (cmd_src == SRC_CPU)
                  ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W] <= 1'b0;
                else if (cmd_src == SRC_AUX)
                  ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W] <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign reg_rdata = rsel_ok ? ctrl_q[reg_rsel] : '0;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_scale
    assign scale[r] = EXTENDED ? ctrl_q[r][SCALE_POS] : 1'b0;
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_slot
    logic [1:0] code_w;
    assign slots[g*SLOT_W +: SLOT_W] =
      ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W +: SLOT_W];
    assign code_w = ctrl_q[g / SLOTS_PER_REG][(g % SLOTS_PER_REG)*SLOT_W +: 2];
    assign reload[g] = (reg_wr && int'(reg_wsel) == g / SLOTS_PER_REG) ||
                       (cmd_go && int'(cmd_gen) == g);

    if (EXTENDED) begin : g_ext_chk
      p_disable_keeps_memory_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && int'(cmd_gen) == g && cmd_op == OP_DISABLE)
          |=> (code_w == 2'b00 && $stable(mem_q[g])));
      p_enable_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && int'(cmd_gen) == g && cmd_op == OP_ENABLE)
          |=> (code_w == $past(mem_q[g])));
    end

    p_write_drops_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && cmd_valid && int'(cmd_gen) == g && int'(reg_wsel) != g / SLOTS_PER_REG)
        |=> $stable(code_w));
  end
endmodule

// File: rtl/fgb_slot_decode.sv
module fgb_slot_decode
  import fgb_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              scale,
  output gen_cfg_t          cfg
);
  logic [DIV_W-1:0]   div_code;
  logic [RATIO_W-1:0] unit_ratio;
  logic [RATIO_W-1:0] even_ratio;

  assign div_code   = slot[SLOT_W-1:2];
  assign unit_ratio = RATIO_W'(div_code) + RATIO_W'(1);
  assign even_ratio = unit_ratio << 1;

  if (EXTENDED) begin : g_ext
    assign cfg.active = slot[1:0] != 2'b00;
    assign cfg.src    = src_e'(slot[1:0]);
    assign cfg.ratio  = scale ? unit_ratio : even_ratio;
  end else begin : g_leg
    logic unused_scale;
    assign unused_scale = scale;
    assign cfg.active = slot[1];
    assign cfg.src    = slot[0] ? SRC_AUX : SRC_CPU;
    assign cfg.ratio  = even_ratio;
  end
endmodule

// File: rtl/fgb_divider.sv
module fgb_divider
  import fgb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  gen_cfg_t cfg,
  input  logic     tick_cpu,
  input  logic     tick_aux,
  input  logic     tick_aux2,
  input  logic     reload,
  output logic     out_tick
);
  logic [RATIO_W-1:0] cnt_q;
  logic               in_tick;
  logic               at_last;

  always_comb begin
    unique case (cfg.src)
      SRC_CPU:  in_tick = tick_cpu;
      SRC_AUX:  in_tick = tick_aux;
      SRC_AUX2: in_tick = tick_aux2;
      default:  in_tick = 1'b0;
    endcase
  end

  assign at_last = cnt_q == (cfg.ratio - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (reload || !cfg.active)  cnt_q <= '0;
    else if (in_tick)                cnt_q <= at_last ? '0 : cnt_q + RATIO_W'(1);
  end

  assign out_tick = cfg.active && in_tick && at_last;

  p_off_holds_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.active |=> cnt_q == '0);
  p_reload_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == '0);
  p_count_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cfg.ratio);
endmodule

// File: rtl/freq_gen_bank.sv
module freq_gen_bank
  import fgb_pkg::*;
#(
  parameter bit EXTENDED = 1'b1,
  parameter int NUM_GEN  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_wsel,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rsel,
  output logic [31:0]       reg_rdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        cmd_gen,
  input  logic [1:0]        cmd_src,
  input  logic              tick_cpu,
  input  logic              tick_aux,
  input  logic              tick_aux2,
  output logic [NUM_GEN-1:0] gen_tick
);
  localparam int NUM_REGS = (NUM_GEN + SLOTS_PER_REG - 1) / SLOTS_PER_REG;

  logic [NUM_GEN*SLOT_W-1:0] slots;
  logic [NUM_REGS-1:0]       scale;
  logic [NUM_GEN-1:0]        reload;

  fgb_regs #(
    .EXTENDED (EXTENDED),
    .NUM_GEN  (NUM_GEN),
    .NUM_REGS (NUM_REGS),
    .RSEL_W   (1),
    .GEN_W    (3)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wsel  (reg_wsel),
    .reg_wdata (reg_wdata),
    .reg_rsel  (reg_rsel),
    .reg_rdata (reg_rdata),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_gen   (cmd_gen),
    .cmd_src   (cmd_src),
    .slots     (slots),
    .scale     (scale),
    .reload    (reload)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    gen_cfg_t cfg;

    fgb_slot_decode #(.EXTENDED(EXTENDED)) u_dec (
      .slot  (slots[g*SLOT_W +: SLOT_W]),
      .scale (scale[g / SLOTS_PER_REG]),
      .cfg   (cfg)
    );

    fgb_divider u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg),
      .tick_cpu  (tick_cpu),
      .tick_aux  (tick_aux),
      .tick_aux2 (tick_aux2),
      .reload    (reload[g]),
      .out_tick  (gen_tick[g])
    );
  end
endmodule

// File: tb/freq_gen_bank_tb.sv
`timescale 1ns/1ps
module freq_gen_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_wsel = 1'b0, reg_rsel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0, cmd_src = '0;
  logic [2:0]  cmd_gen = '0;
  logic        tick_cpu = 1'b0, tick_aux = 1'b0, tick_aux2 = 1'b0;
  logic [31:0] ext_rd, leg_rd;
  logic [5:0]  ext_tick, leg_tick;

  int n_checks = 0;
  int n_bad = 0;
  int tick_mode = 0;
  string cur_req = "R1";
  bit done = 0;

  int unsigned m_reg [2][2];
  int          m_mem [2][6];
  int          m_cnt [2][6];

  always #2.5 clk = ~clk;

  freq_gen_bank #(.EXTENDED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(ext_rd), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_gen(cmd_gen), .cmd_src(cmd_src), .tick_cpu(tick_cpu), .tick_aux(tick_aux),
    .tick_aux2(tick_aux2), .gen_tick(ext_tick));

  freq_gen_bank #(.EXTENDED(1'b0)) u_dut_leg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(leg_rd), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_gen(cmd_gen), .cmd_src(cmd_src), .tick_cpu(tick_cpu), .tick_aux(tick_aux),
    .tick_aux2(tick_aux2), .gen_tick(leg_tick));

  task automatic chk(string req, int unsigned act, int unsigned exp, string what);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned slot_of(int m, int g);
    return (m_reg[m][g/3] >> (10*(g%3))) & 32'h3ff;
  endfunction

  function automatic int ratio_of(int m, int g);
    int n = int'(slot_of(m, g) >> 2);
    if (m == 1 && ((m_reg[m][g/3] >> 30) & 1) == 1) return n + 1;
    return 2 * (n + 1);
  endfunction

  function automatic bit active_of(int m, int g);
    int unsigned s = slot_of(m, g);
    if (m == 0) return ((s >> 1) & 1) == 1;
    return (s & 3) != 0;
  endfunction

  function automatic bit tick_of(int m, int g);
    int unsigned s = slot_of(m, g);
    if (m == 0) return (s & 1) ? tick_aux : tick_cpu;
    case (s & 3)
      1: return tick_aux2;
      2: return tick_cpu;
      3: return tick_aux;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare_now();
    for (int m = 0; m < 2; m++) begin
      int unsigned exp = 0;
      for (int g = 0; g < 6; g++)
        if (active_of(m, g) && tick_of(m, g) && m_cnt[m][g] == ratio_of(m, g) - 1)
          exp |= (1 << g);
      chk(m == 0 ? "R4" : cur_req, m == 0 ? leg_tick : ext_tick, exp,
          m == 0 ? "legacy gen_tick" : "extended gen_tick");
      chk("R2", m == 0 ? leg_rd : ext_rd, m_reg[m][reg_rsel], "reg_rdata");
    end
  endtask

  task automatic model_step();
    bit go = cmd_valid && !reg_wr && cmd_op != 0 && cmd_gen < 6;
    int nc [2][6];
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 6; g++) begin
        bit clr = (reg_wr && int'(reg_wsel) == g/3) || (go && int'(cmd_gen) == g);
        if (clr || !active_of(m, g)) nc[m][g] = 0;
        else if (tick_of(m, g)) nc[m][g] = (m_cnt[m][g] == ratio_of(m, g) - 1) ? 0 : m_cnt[m][g] + 1;
        else nc[m][g] = m_cnt[m][g];
      end
    for (int m = 0; m < 2; m++) begin
      if (reg_wr) begin
        m_reg[m][reg_wsel] = reg_wdata & (m == 1 ? 32'h7fffffff : 32'h3fffffff);
        if (m == 1)
          for (int k = 0; k < 3; k++) begin
            int code = int'((reg_wdata >> (10*k)) & 3);
            if (code != 0) m_mem[m][int'(reg_wsel)*3 + k] = code;
          end
      end else if (go) begin
        int g = int'(cmd_gen);
        int sh = 10 * (g % 3);
        int r = g / 3;
        int code = int'((m_reg[m][r] >> sh) & 3);
        if (m == 1) begin
          case (cmd_op)
            1: m_reg[m][r] = (m_reg[m][r] & ~(32'h3 << sh)) | (int'(m_mem[m][g]) << sh);
            2: m_reg[m][r] = m_reg[m][r] & ~(32'h3 << sh);
            3: if (cmd_src != 0) begin
                 m_mem[m][g] = cmd_src;
                 if (code != 0) m_reg[m][r] = (m_reg[m][r] & ~(32'h3 << sh)) | (int'(cmd_src) << sh);
               end
            default: ;
          endcase
        end else begin
          case (cmd_op)
            1: m_reg[m][r] = m_reg[m][r] | (32'h2 << sh);
            2: m_reg[m][r] = m_reg[m][r] & ~(32'h2 << sh);
            3: if (cmd_src == 2) m_reg[m][r] = m_reg[m][r] & ~(32'h1 << sh);
               else if (cmd_src == 3) m_reg[m][r] = m_reg[m][r] | (32'h1 << sh);
            default: ;
          endcase
        end
      end
    end
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 6; g++) m_cnt[m][g] = nc[m][g];
  endtask

  task automatic cycle();
    case (tick_mode)
      0: begin tick_cpu = 0; tick_aux = 0; tick_aux2 = 0; end
      1: begin tick_cpu = 1; tick_aux = 1; tick_aux2 = 1; end
      default: begin
        tick_cpu = ($urandom % 2) == 1; tick_aux = ($urandom % 3) == 0; tick_aux2 = ($urandom % 2) == 0;
      end
    endcase
    #1;
    compare_now();
    @(posedge clk);
    model_step();
    @(negedge clk);
    reg_wr = 0;
    cmd_valid = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(bit sel, logic [31:0] data);
    reg_wr = 1; reg_wsel = sel; reg_wdata = data;
    cycle();
  endtask

  task automatic cmd(int op, int gen, int src);
    cmd_valid = 1; cmd_op = 2'(op); cmd_gen = 3'(gen); cmd_src = 2'(src);
    cycle();
  endtask

  function automatic logic [31:0] sl(int n, int code);
    return 32'((n << 2) | code);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired before end of stimulus");
    finish_run();
  end

  initial begin
    logic [31:0] before_ext, before_leg;
    for (int m = 0; m < 2; m++) begin
      m_reg[m][0] = 0; m_reg[m][1] = 0;
      for (int g = 0; g < 6; g++) begin m_mem[m][g] = 1; m_cnt[m][g] = 0; end
    end
    tick_cpu = 1; tick_aux = 1; tick_aux2 = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state of registers and outputs
    reg_rsel = 0; #0.5;
    chk("R1", ext_rd, 0, "ext reg0 in reset");
    chk("R1", leg_rd, 0, "leg reg0 in reset");
    chk("R1", {26'd0, ext_tick}, 0, "ext ticks in reset");
    chk("R1", {26'd0, leg_tick}, 0, "leg ticks in reset");
    reg_rsel = 1; #0.5;
    chk("R1", ext_rd, 0, "ext reg1 in reset");
    chk("R1", leg_rd, 0, "leg reg1 in reset");
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; tick_mode = 1; run(4);

    // R5 / R2: mixed sources, ratio 1 and 3, unused bits masked
    cur_req = "R5"; reg_rsel = 0; tick_mode = 2;
    wr(0, sl(0,2) | (sl(2,3) << 10) | (sl(1,1) << 20) | 32'hC000_0000);
    chk("R2", ext_rd, 32'h4050_2C02, "ext readback masks bit31");
    chk("R2", leg_rd, 32'h0050_2C02, "leg readback masks bits31:30");
    run(300);

    // R6: scale clear -> even ratios in extended layout
    cur_req = "R6";
    wr(0, sl(0,2) | (sl(2,3) << 10) | (sl(1,1) << 20));
    run(300);

    // R3: upper register slots
    cur_req = "R3"; reg_rsel = 1;
    wr(1, sl(3,3) | (sl(0,2) << 10) | (sl(5,1) << 20) | 32'h4000_0000);
    run(300);

    // R7: pass-through ratio 1 and the 512 extreme
    cur_req = "R7"; tick_mode = 1; reg_rsel = 0;
    wr(0, sl(0,2) | 32'h4000_0000);
    run(20);
    wr(1, sl(255,2) | (sl(255,3) << 10));
    run(1100);

    // R8: turning a generator off mid count
    cur_req = "R8"; tick_mode = 2;
    wr(1, sl(6,2) | 32'h4000_0000);
    run(4);
    wr(1, sl(6,0) | 32'h4000_0000);
    run(15);
    wr(1, sl(6,2) | 32'h4000_0000);
    run(30);

    // R9: rewrite reloads counters
    cur_req = "R9"; tick_mode = 1;
    wr(1, sl(4,2) | (sl(2,3) << 10) | 32'h4000_0000);
    run(3);
    wr(1, sl(4,2) | (sl(2,3) << 10) | 32'h4000_0000);
    run(12);
    cmd(3, 3, 2);
    run(12);

    // R10 / R11: command sequences
    cur_req = "R10"; reg_rsel = 0; tick_mode = 2;
    wr(0, sl(1,2) | (sl(2,3) << 10) | (sl(0,1) << 20) | 32'h4000_0000);
    cmd(2, 1, 0);
    chk("R10", (ext_rd >> 10) & 3, 0, "disable clears code");
    chk("R11", (leg_rd >> 11) & 1, 0, "legacy disable clears enable");
    run(20);
    cmd(3, 1, 1);
    chk("R10", (ext_rd >> 10) & 3, 0, "set source while off keeps code zero");
    cmd(1, 1, 0);
    chk("R10", (ext_rd >> 10) & 3, 1, "enable restores remembered code");
    chk("R11", (leg_rd >> 11) & 1, 1, "legacy enable sets enable");
    run(20);
    cmd(3, 1, 3);
    chk("R10", (ext_rd >> 10) & 3, 3, "set source while on writes code");
    chk("R11", (leg_rd >> 10) & 1, 1, "legacy source aux");
    cmd(3, 1, 2);
    chk("R11", (leg_rd >> 10) & 1, 0, "legacy source cpu");
    cmd(2, 1, 0);
    cmd(1, 1, 0);
    chk("R10", (ext_rd >> 10) & 3, 2, "re-enable restores last source");
    run(20);

    // R12: dropped commands
    cur_req = "R12";
    reg_wr = 1; reg_wsel = 1; reg_wdata = sl(3,2);
    cmd_valid = 1; cmd_op = 2; cmd_gen = 0; cmd_src = 0;
    cycle();
    chk("R12", ext_rd & 3, 2, "command during write dropped");
    chk("R12", (leg_rd >> 1) & 1, 1, "legacy command during write dropped");
    before_ext = ext_rd; before_leg = leg_rd;
    cmd(2, 6, 0);
    cmd(2, 7, 0);
    cmd(0, 0, 0);
    chk("R12", ext_rd, before_ext, "out of range or nop command ignored");
    chk("R12", leg_rd, before_leg, "legacy out of range or nop command ignored");
    run(40);

    finish_run();
  end
endmodule